// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a memory-mapped periodic timer. A divide-by-16 prescaler turns the system clock into ticks. A 20-bit counter climbs one step per tick until it reaches a programmable period value. It then returns to zero, sets a sticky wrap flag and increments a 12-bit wrap count. Software picks the period as the desired number of ticks minus one. It reads the live count and the number of wraps since the last acknowledge as one 32-bit word.

There are two read views of that word. The acknowledging view clears the flag and the wrap count as a side effect. The snapshot view returns the same data and changes nothing. A level interrupt follows the flag, gated by an interrupt-enable bit. When the enable bit is cleared, the counter does not stop at once. It keeps counting until it next reaches zero, so a stopped timer always rests at zero.

Register bus: byte offsets on `addr`. A write happens on `wr_en`. A read returns data combinationally on `rdata` in the cycle `rd_en` is high. Any read side effect takes place at the clock edge that ends that cycle.

Top module: `pit_top`

## Requirements
- R1: After reset, all four registers read 0, the counter is stopped and `irq` is low.
- R2: Offset 0x0 is the mode register, with the period value in bits 19:0, the run enable in bit 24 and the interrupt enable in bit 25. All other bits read 0. Offset 0x4 is status, with the wrap flag in bit 0. Offsets 0x8 (acknowledging view) and 0xC (snapshot view) both hold the wrap count in bits 31:20 and the counter in bits 19:0.
- R3: While running, the counter advances once every 16 clock cycles. The first step lands 16 edges after the edge that wrote the enable.
- R4: On a tick with the counter at or above the period value, the counter goes to 0, the flag is set and the wrap count increments. One period therefore spans the period value plus one ticks.
- R5: Reading the snapshot view (0xC) or the status register changes no state.
- R6: Reading the acknowledging view (0x8) returns the data as it was before the read. From the next cycle, the flag and the wrap count are 0.
- R7: `irq` is high exactly when the flag is set and the interrupt enable is 1.
- R8: After the run enable is cleared, counting continues until the counter returns to 0. It then stops and holds 0, and no further wraps occur.
- R9: When a wrap and an acknowledging read fall in the same cycle, the flag stays set and the wrap count becomes 1.
- R10: The wrap count rolls over modulo 4096.
- R11: Writes to offsets other than 0x0 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| irq | output | 1 | Level interrupt request |

## Verification
A table of period values against elapsed cycle counts covers several cases. These include windows ending one edge before the first tick and exactly on it, a period value of zero where every tick wraps, and windows spanning several wraps. Together they separate an off-by-one in the prescaler from one in the period compare. Directed sequences then place an acknowledging read exactly on a wrap edge, which separates "wrap wins" from "clear wins". They interleave snapshot and acknowledging reads to show which one clears. They clear the enable mid-period and show that counting stops after the run-down rather than at once or never. A run of 4097 wraps exposes a wrap count that saturates instead of rolling over.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_MODE   = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_VALUE  = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_IMAGE  = 4'hC;

  localparam int unsigned EN_BIT  = 24;
  localparam int unsigned IEN_BIT = 25;

  typedef enum logic [2:0] {
    SEL_MODE,
    SEL_STATUS,
    SEL_VALUE,
    SEL_IMAGE,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_MODE:   return SEL_MODE;
      OFF_STATUS: return SEL_STATUS;
      OFF_VALUE:  return SEL_VALUE;
      OFF_IMAGE:  return SEL_IMAGE;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  function automatic logic [PW-1:0] next_phase(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign tick = run && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_q <= '0;
    else if (!run)  phase_q <= '0;
    else            phase_q <= next_phase(phase_q);
  end

  generate
    if (DIV > 1) begin : g_spacing_chk
      assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned WRAP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic [CNT_W-1:0]  period,
  input  logic              ack_rd,
  output logic              active,
  output logic              wrap_ev,
  output logic [CNT_W-1:0]  cv,
  output logic [WRAP_W-1:0] wraps,
  output logic              flag
);
  function automatic logic reaches_end(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] p);
    return c >= p;
  endfunction

  function automatic logic [CNT_W-1:0] step_cv(input logic [CNT_W-1:0] c,
                                               input logic at_end);
    return at_end ? '0 : c + 1'b1;
  endfunction

  function automatic logic [WRAP_W-1:0] step_wraps(input logic [WRAP_W-1:0] w,
                                                   input logic cleared);
    return cleared ? WRAP_W'(1) : w + 1'b1;
  endfunction

  assign active  = en || (cv != '0);
  assign wrap_ev = tick && reaches_end(cv, period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv    <= '0;
      wraps <= '0;
      flag  <= 1'b0;
    end else begin
      if (tick) cv <= step_cv(cv, wrap_ev);
      if (wrap_ev) begin
        flag  <= 1'b1;
        wraps <= step_wraps(wraps, ack_rd);
      end else if (ack_rd) begin
        flag  <= 1'b0;
        wraps <= '0;
      end
    end
  end

  assert_cv_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cv));
  assert_wrap_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (flag && cv == '0));
  assert_wrap_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && !ack_rd) |=> (wraps == WRAP_W'($past(wraps) + 1'b1)));
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !wrap_ev) |=> (!flag && wraps == '0));
  assert_wrap_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && wrap_ev) |=> (flag && wraps == WRAP_W'(1)));
  assert_stays_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && cv == '0) |=> (cv == '0));
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned WRAP_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cv,
  input  logic [WRAP_W-1:0] wraps,
  input  logic              flag,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  period,
  output logic              en,
  output logic              ien,
  output logic              ack_rd
);
  reg_sel_e sel;
  logic     mode_wr;

  assign sel     = decode_sel(addr);
  assign mode_wr = wr_en && (sel == SEL_MODE);
  assign ack_rd  = rd_en && (sel == SEL_VALUE);

  function automatic logic [DATA_W-1:0] pack_count(input logic [WRAP_W-1:0] w,
                                                   input logic [CNT_W-1:0] c);
    logic [DATA_W-1:0] r;
    r = '0;
    r[CNT_W +: WRAP_W] = w;
    r[CNT_W-1:0]       = c;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pack_mode(input logic [CNT_W-1:0] p,
                                                  input logic e,
                                                  input logic ie);
    logic [DATA_W-1:0] r;
    r = '0;
    r[CNT_W-1:0] = p;
    r[EN_BIT]    = e;
    r[IEN_BIT]   = ie;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period <= '0;
      en     <= 1'b0;
      ien    <= 1'b0;
    end else if (mode_wr) begin
      period <= wdata[CNT_W-1:0];
      en     <= wdata[EN_BIT];
      ien    <= wdata[IEN_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_MODE:   rdata = pack_mode(period, en, ien);
        SEL_STATUS: rdata = DATA_W'(flag);
        SEL_VALUE,
        SEL_IMAGE:  rdata = pack_count(wraps, cv);
        default:    rdata = '0;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata[DATA_W-1:IEN_BIT+1], wdata[EN_BIT-1:CNT_W]};

  assert_mode_only_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> ($stable(period) && $stable(en) && $stable(ien)));
endmodule

// File: rtl/pit_top.sv
module pit_top
  import pit_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 16,
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned WRAP_W    = 12,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int unsigned WORD_USED = CNT_W + WRAP_W;

  logic              tick, active, wrap_ev, flag, en, ien, ack_rd;
  logic [CNT_W-1:0]  cv, period;
  logic [WRAP_W-1:0] wraps;

  pit_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(active), .tick(tick)
  );

  pit_counter #(.CNT_W(CNT_W), .WRAP_W(WRAP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .period(period),
    .ack_rd(ack_rd), .active(active), .wrap_ev(wrap_ev), .cv(cv),
    .wraps(wraps), .flag(flag)
  );

  pit_regs #(.CNT_W(CNT_W), .WRAP_W(WRAP_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cv(cv), .wraps(wraps), .flag(flag), .rdata(rdata),
    .period(period), .en(en), .ien(ien), .ack_rd(ack_rd)
  );

  assign irq = flag && ien;

  initial begin
    assert_word_fits_R2: assert (WORD_USED <= DATA_W && IEN_BIT < DATA_W);
  end

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && ien && !mode_change) |=> irq);

  logic mode_change;
  assign mode_change = wr_en && (addr == OFF_MODE);
endmodule

// File: tb/pit_top_bench.sv
module pit_top_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 8;
  localparam logic [19:0] V_PIV  [NVEC] = '{20'd3, 20'd3, 20'd3, 20'd5, 20'd2, 20'd7, 20'd0, 20'd9};
  localparam int          V_WAIT [NVEC] = '{15, 16, 64, 100, 200, 130, 40, 47};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  pit_top u_pit_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected count word after a number of clock edges from the enabling write.
  function automatic logic [31:0] model_word(input int piv, input int edges);
    int ticks, wr, c;
    ticks = edges / 16;
    wr = (ticks / (piv + 1)) % 4096;
    c  = ticks % (piv + 1);
    return {wr[11:0], c[19:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R1: reset state
    bus_rd(4'h0, d); check("R1 mode", d, 32'h0);
    bus_rd(4'h4, d); check("R1 status", d, 32'h0);
    bus_rd(4'h8, d); check("R1 value", d, 32'h0);
    bus_rd(4'hC, d); check("R1 image", d, 32'h0);
    #1 check("R1 irq", {31'b0, irq}, 32'h0);

    // R2: mode field layout
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h0, d); check("R2 mode readback", d, 32'h030F_FFFF);

    // R3/R4: table of period values and elapsed edges
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      bus_wr(4'h0, 32'h0100_0000 | {12'h0, V_PIV[i]});
      repeat (V_WAIT[i]) @(negedge clk);
      bus_rd(4'hC, d);
      check("R3 R4 count word", d, model_word(int'(V_PIV[i]), V_WAIT[i]));
      bus_rd(4'h4, d);
      check("R4 flag", d, {31'b0, model_word(int'(V_PIV[i]), V_WAIT[i] + 1) >= 32'h0010_0000});
      #1 check("R7 irq gated off", {31'b0, irq}, 32'h0);
    end

    // R5/R6: snapshot vs acknowledging read, period 4 ticks
    do_reset();
    bus_wr(4'h0, 32'h0100_0003);
    repeat (70) @(negedge clk);
    bus_rd(4'hC, d); check("R5 image before ack", d, 32'h0010_0000);
    bus_rd(4'h4, d); check("R5 status unchanged", d, 32'h1);
    bus_rd(4'h8, d); check("R6 value returns old data", d, 32'h0010_0000);
    bus_rd(4'hC, d); check("R6 wraps cleared", d, 32'h0);
    bus_rd(4'h4, d); check("R6 flag cleared", d, 32'h0);

    // R7: interrupt follows flag and enable
    do_reset();
    bus_wr(4'h0, 32'h0300_0001);
    repeat (31) @(negedge clk);
    #1 check("R7 irq before wrap", {31'b0, irq}, 32'h0);
    @(negedge clk);
    #1 check("R7 irq after wrap", {31'b0, irq}, 32'h1);
    bus_wr(4'h0, 32'h0100_0001);
    #1 check("R7 irq masked", {31'b0, irq}, 32'h0);
    bus_rd(4'h4, d); check("R7 flag kept while masked", d, 32'h1);

    // R9: acknowledging read on a wrap edge
    do_reset();
    bus_wr(4'h0, 32'h0100_0000);
    repeat (31) @(negedge clk);
    bus_rd(4'h8, d); check("R9 value before edge", d, 32'h0010_0000);
    bus_rd(4'hC, d); check("R9 wrap wins count", d, 32'h0010_0000);
    bus_rd(4'h4, d); check("R9 wrap wins flag", d, 32'h1);

    // R8: run-down after disable
    do_reset();
    bus_wr(4'h0, 32'h0100_0009);
    repeat (50) @(negedge clk);
    bus_wr(4'h0, 32'h0000_0009);
    repeat (60) @(negedge clk);
    bus_rd(4'hC, d); check("R8 still counting", d, 32'h0000_0006);
    repeat (88) @(negedge clk);
    bus_rd(4'hC, d); check("R8 stopped at zero", d, 32'h0010_0000);
    repeat (199) @(negedge clk);
    bus_rd(4'hC, d); check("R8 stays stopped", d, 32'h0010_0000);

    // R11: writes elsewhere ignored
    do_reset();
    bus_wr(4'h0, 32'h0000_0005);
    bus_wr(4'h4, 32'hFFFF_FFFF);
    bus_wr(4'h8, 32'hFFFF_FFFF);
    bus_wr(4'hC, 32'hFFFF_FFFF);
    repeat (40) @(negedge clk);
    bus_rd(4'h0, d); check("R11 mode kept", d, 32'h0000_0005);
    bus_rd(4'h4, d); check("R11 status kept", d, 32'h0);
    bus_rd(4'hC, d); check("R11 counter idle", d, 32'h0);

    // R10: wrap count rolls over after 4096
    do_reset();
    bus_wr(4'h0, 32'h0100_0000);
    repeat (16 * 4097) @(negedge clk);
    bus_rd(4'hC, d); check("R10 rollover", d, 32'h0010_0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule